// File: doc/BRIEF.md
# Comparator Phase Clock Generator

This block sequences the strobes that drive one comparator decision in a successive-approximation converter. In that converter the two DAC buffers also serve as open-loop preamplifiers, and a regenerative latch follows them. A single pulse on `bit_start` launches a bit cycle. The block then raises the preamplifier enable of the active capacitor set. Near the end of that comparison slot it issues a brief transfer pulse that hands the preamplifier outputs to the latch, and latch evaluation begins in the same cycle. After the transfer it shuts off the amplifier bias. It then registers the latch decision with a one-cycle valid strobe, and finally precharges the latch nodes with a reset strobe.

Every phase length is a parameter counted in base-clock cycles. The active capacitor set is tracked inside the block. It begins at set A after reset and swaps after each completed bit, so a converter only has to pulse `bit_start` once per bit. The analog latch output arrives as the `latch_dec` input.

Top module: `cmp_phase_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, every strobe output, `dec_valid` and `dec_out` are low.
- R2: When `bit_start` is high at a clock edge while the block is idle, the comparison slot starts in the next cycle. Exactly one bit of `pre_en` is then high for PRE_CYC+XFER_CYC cycles, and no other strobe is high during the first PRE_CYC of those cycles.
- R3: The first bit after reset uses set A, which is `pre_en` = 2'b01. Each later bit uses the other set from the bit before it: 2'b10, then 2'b01, and so on.
- R4: `xfer_pulse` is high for exactly XFER_CYC cycles, which are the last cycles of the comparison slot. It falls in the same cycle as `pre_en`.
- R5: `latch_en` rises in the same cycle as `xfer_pulse` and stays high for XFER_CYC+LAT_CYC cycles.
- R6: `bias_off` rises in the first cycle after the transfer pulse ends. It stays high until the end of the latch reset, and it is never high together with `pre_en`.
- R7: `latch_dec` is sampled only at the edge that ends the last `latch_en` cycle. In the following cycle `dec_valid` is high for exactly one cycle and `dec_out` holds the sampled value. `dec_out` holds that value until the next decision, and `latch_dec` in any other cycle has no effect.
- R8: `latch_rst` is high for RST_CYC cycles, starting in the cycle right after the `dec_valid` cycle. It never coincides with `latch_en`, `xfer_pulse`, `pre_en` or `dec_valid`.
- R9: `bit_start` is ignored while a bit cycle is in progress, including the last reset cycle. The cycle after `latch_rst` falls is idle, with all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast base clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_start | input | 1 | Launches one bit cycle when idle |
| latch_dec | input | 1 | Decision level from the regenerative latch |
| pre_en | output | 2 | Preamplifier enable per capacitor set (bit 0 = set A) |
| xfer_pulse | output | 1 | Connects preamplifier outputs to latch inputs |
| latch_en | output | 1 | Latch evaluate and input power gate enable |
| bias_off | output | 1 | Shuts off both amplifier bias currents |
| latch_rst | output | 1 | Precharges the latch nodes |
| dec_out | output | 1 | Registered comparator decision |
| dec_valid | output | 1 | One-cycle strobe marking a new `dec_out` |

## Verification
The bench runs long chains of consecutive bits whose decisions follow an irregular pattern. The chains reveal whether the set selection alternates or sticks, and whether the capture copies the wanted level rather than a stale one. In each bit, `latch_dec` carries the inverse of the wanted value in every cycle except the last latch cycle, so a capture made one cycle early or late is caught. Extra `bit_start` pulses during a busy bit, one of them in the last reset cycle, would shift or extend the strobe profile if they were accepted. Idle stretches with a toggling `latch_dec` show whether `dec_out` can change outside a decision.

// File: rtl/cmpclk_pkg.sv
package cmpclk_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_PRE   = 3'd1,
    PH_XFER  = 3'd2,
    PH_LATCH = 3'd3,
    PH_DONE  = 3'd4,
    PH_RST   = 3'd5
  } phase_e;

  localparam int NUM_SETS = 2;
endpackage

// File: rtl/cmpclk_seq.sv
module cmpclk_seq
  import cmpclk_pkg::*;
#(
  parameter int PRE_CYC  = 4,
  parameter int XFER_CYC = 1,
  parameter int LAT_CYC  = 3,
  parameter int RST_CYC  = 2,
  parameter int CW       = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output phase_e ph,
  output phase_e ph_nxt,
  output logic   set_q
);
  logic [CW-1:0] cnt, cnt_nxt;
  logic          last;

  assign last = (cnt == '0);

  always_comb begin
    ph_nxt  = ph;
    cnt_nxt = cnt;
    unique case (ph)
      PH_IDLE: if (start) begin
        ph_nxt  = PH_PRE;
        cnt_nxt = CW'(PRE_CYC - 1);
      end
      PH_PRE: if (last) begin
        ph_nxt  = PH_XFER;
        cnt_nxt = CW'(XFER_CYC - 1);
      end else cnt_nxt = cnt - 1'b1;
      PH_XFER: if (last) begin
        ph_nxt  = PH_LATCH;
        cnt_nxt = CW'(LAT_CYC - 1);
      end else cnt_nxt = cnt - 1'b1;
      PH_LATCH: if (last) begin
        ph_nxt  = PH_DONE;
        cnt_nxt = '0;
      end else cnt_nxt = cnt - 1'b1;
      PH_DONE: begin
        ph_nxt  = PH_RST;
        cnt_nxt = CW'(RST_CYC - 1);
      end
      PH_RST: if (last) begin
        ph_nxt  = PH_IDLE;
        cnt_nxt = '0;
      end else cnt_nxt = cnt - 1'b1;
      default: begin
        ph_nxt  = PH_IDLE;
        cnt_nxt = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      set_q <= 1'b0;
    end else begin
      ph  <= ph_nxt;
      cnt <= cnt_nxt;
      if (ph == PH_RST && last) set_q <= ~set_q;
    end
  end
endmodule

// File: rtl/cmpclk_strobes.sv
module cmpclk_strobes
  import cmpclk_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  phase_e              ph_nxt,
  input  logic                set_q,
  output logic [NUM_SETS-1:0] pre_en,
  output logic                xfer,
  output logic                lat_en,
  output logic                bias_off,
  output logic                lat_rst,
  output logic                done
);
  logic in_cmp;
  assign in_cmp = (ph_nxt == PH_PRE) || (ph_nxt == PH_XFER);

  genvar g;
  generate
    for (g = 0; g < NUM_SETS; g++) begin : g_set
      logic pe_q;
      always_ff @(posedge clk) begin
        if (rst) pe_q <= 1'b0;
        else     pe_q <= in_cmp && (set_q == 1'(g));
      end
      assign pre_en[g] = pe_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer     <= 1'b0;
      lat_en   <= 1'b0;
      bias_off <= 1'b0;
      lat_rst  <= 1'b0;
      done     <= 1'b0;
    end else begin
      xfer     <= (ph_nxt == PH_XFER);
      lat_en   <= (ph_nxt == PH_XFER) || (ph_nxt == PH_LATCH);
      bias_off <= (ph_nxt == PH_LATCH) || (ph_nxt == PH_DONE) || (ph_nxt == PH_RST);
      lat_rst  <= (ph_nxt == PH_RST);
      done     <= (ph_nxt == PH_DONE);
    end
  end
endmodule

// File: rtl/cmpclk_capture.sv
module cmpclk_capture (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic din,
  output logic dout
);
  always_ff @(posedge clk) begin
    if (rst)       dout <= 1'b0;
    else if (take) dout <= din;
  end
endmodule

// File: rtl/cmp_phase_gen.sv
module cmp_phase_gen
  import cmpclk_pkg::*;
#(
  parameter int PRE_CYC  = 4,
  parameter int XFER_CYC = 1,
  parameter int LAT_CYC  = 3,
  parameter int RST_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_start,
  input  logic       latch_dec,
  output logic [1:0] pre_en,
  output logic       xfer_pulse,
  output logic       latch_en,
  output logic       bias_off,
  output logic       latch_rst,
  output logic       dec_out,
  output logic       dec_valid
);
  localparam int MAX_AB = (PRE_CYC > XFER_CYC) ? PRE_CYC : XFER_CYC;
  localparam int MAX_CD = (LAT_CYC > RST_CYC) ? LAT_CYC : RST_CYC;
  localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = (MAXC < 2) ? 1 : $clog2(MAXC);

  phase_e ph, ph_nxt;
  logic   set_q;
  logic   take;

  cmpclk_seq #(
    .PRE_CYC (PRE_CYC),
    .XFER_CYC(XFER_CYC),
    .LAT_CYC (LAT_CYC),
    .RST_CYC (RST_CYC),
    .CW      (CW)
  ) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (bit_start),
    .ph    (ph),
    .ph_nxt(ph_nxt),
    .set_q (set_q)
  );

  cmpclk_strobes u_stb (
    .clk     (clk),
    .rst     (rst),
    .ph_nxt  (ph_nxt),
    .set_q   (set_q),
    .pre_en  (pre_en),
    .xfer    (xfer_pulse),
    .lat_en  (latch_en),
    .bias_off(bias_off),
    .lat_rst (latch_rst),
    .done    (dec_valid)
  );

  assign take = (ph == PH_LATCH) && (ph_nxt == PH_DONE);

  cmpclk_capture u_cap (
    .clk (clk),
    .rst (rst),
    .take(take),
    .din (latch_dec),
    .dout(dec_out)
  );
endmodule

// File: rtl/cmp_phase_gen_chk.sv
module cmp_phase_gen_chk #(
  parameter int PRE_CYC  = 4,
  parameter int XFER_CYC = 1,
  parameter int LAT_CYC  = 3,
  parameter int RST_CYC  = 2
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] pre_en,
  input logic       xfer_pulse,
  input logic       latch_en,
  input logic       bias_off,
  input logic       latch_rst,
  input logic       dec_out,
  input logic       dec_valid
);
  int         xrun;
  logic [1:0] prev_pe, last_pe;
  logic       seen;
  logic       pe_rise;

  assign pe_rise = (pre_en != 2'b00) && (prev_pe == 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      xrun    <= 0;
      prev_pe <= 2'b00;
      last_pe <= 2'b00;
      seen    <= 1'b0;
    end else begin
      xrun    <= xfer_pulse ? xrun + 1 : 0;
      prev_pe <= pre_en;
      if (pe_rise) begin
        last_pe <= pre_en;
        seen    <= 1'b1;
      end
    end
  end

  a_r2_pre_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pre_en));

  a_r3_set_swaps: assert property (@(posedge clk) disable iff (rst)
    (pe_rise && seen) |-> (pre_en != last_pe));

  a_r4_xfer_in_slot: assert property (@(posedge clk) disable iff (rst)
    xfer_pulse |-> (pre_en != 2'b00));

  a_r4_xfer_width: assert property (@(posedge clk) disable iff (rst)
    (xfer_pulse && xrun == XFER_CYC - 1) |=> !xfer_pulse);

  a_r4_xfer_full: assert property (@(posedge clk) disable iff (rst)
    $fell(xfer_pulse) |-> ($past(xrun) == XFER_CYC - 1) && (pre_en == 2'b00));

  a_r5_latch_with_xfer: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_pulse) |-> $rose(latch_en));

  a_r6_bias_after_xfer: assert property (@(posedge clk) disable iff (rst)
    $fell(xfer_pulse) |-> bias_off);

  a_r6_bias_not_pre: assert property (@(posedge clk) disable iff (rst)
    bias_off |-> (pre_en == 2'b00));

  a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);

  a_r7_dec_only_on_valid: assert property (@(posedge clk) disable iff (rst)
    !$stable(dec_out) |-> dec_valid);

  a_r8_reset_follows: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> latch_rst);

  a_r8_reset_alone: assert property (@(posedge clk) disable iff (rst)
    latch_rst |-> (!latch_en && !xfer_pulse && !dec_valid && pre_en == 2'b00));
endmodule

bind cmp_phase_gen cmp_phase_gen_chk #(
  .PRE_CYC (PRE_CYC),
  .XFER_CYC(XFER_CYC),
  .LAT_CYC (LAT_CYC),
  .RST_CYC (RST_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pre_en    (pre_en),
  .xfer_pulse(xfer_pulse),
  .latch_en  (latch_en),
  .bias_off  (bias_off),
  .latch_rst (latch_rst),
  .dec_out   (dec_out),
  .dec_valid (dec_valid)
);

// File: tb/tb_cmp_phase_gen.sv
module tb_cmp_phase_gen;
  localparam int P = 4;
  localparam int X = 2;
  localparam int L = 3;
  localparam int R = 2;
  localparam int T = P + X + L + 1 + R;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_start = 1'b0;
  logic       latch_dec = 1'b0;
  logic [1:0] pre_en;
  logic       xfer_pulse, latch_en, bias_off, latch_rst, dec_out, dec_valid;

  int   n_chk = 0;
  int   n_bad = 0;
  logic exp_set = 1'b0;
  logic exp_dec = 1'b0;

  always #5 clk = ~clk;

  cmp_phase_gen #(.PRE_CYC(P), .XFER_CYC(X), .LAT_CYC(L), .RST_CYC(R)) dut (
    .clk(clk), .rst(rst), .bit_start(bit_start), .latch_dec(latch_dec),
    .pre_en(pre_en), .xfer_pulse(xfer_pulse), .latch_en(latch_en),
    .bias_off(bias_off), .latch_rst(latch_rst), .dec_out(dec_out),
    .dec_valid(dec_valid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " pre_en"}, pre_en, 0);
    chk({tag, " xfer"}, xfer_pulse, 0);
    chk({tag, " latch_en"}, latch_en, 0);
    chk({tag, " bias_off"}, bias_off, 0);
    chk({tag, " latch_rst"}, latch_rst, 0);
    chk({tag, " dec_valid"}, dec_valid, 0);
  endtask

  // one bit cycle; poke_a/poke_b give cycle indices for stray starts
  task automatic run_bit(input logic val, input int poke_a, input int poke_b);
    logic [1:0] pe_exp;
    pe_exp = exp_set ? 2'b10 : 2'b01;
    @(negedge clk);
    bit_start = 1'b1;
    latch_dec = ~val;
    for (int k = 1; k <= T + 1; k++) begin
      @(negedge clk);
      bit_start = 1'b0;
      chk("R2 R3 pre_en", pre_en, (k <= P + X) ? int'(pe_exp) : 0);
      chk("R4 xfer_pulse", xfer_pulse, (k > P && k <= P + X) ? 1 : 0);
      chk("R5 latch_en", latch_en, (k > P && k <= P + X + L) ? 1 : 0);
      chk("R6 bias_off", bias_off, (k > P + X && k <= T) ? 1 : 0);
      chk("R7 dec_valid", dec_valid, (k == P + X + L + 1) ? 1 : 0);
      chk("R8 latch_rst", latch_rst, (k > P + X + L + 1 && k <= T) ? 1 : 0);
      if (k == P + X + L + 1 || k == T + 1) chk("R7 dec_out", dec_out, val);
      if (k < P + X + L + 1) chk("R7 dec_out held", dec_out, exp_dec);
      latch_dec = (k == P + X + L) ? val : ~val;
      if (k == poke_a || k == poke_b) bit_start = 1'b1;
    end
    exp_dec = val;
    exp_set = ~exp_set;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    chk("R1 dec_out", dec_out, 0);
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R1 after release");
    chk("R1 dec_out after release", dec_out, 0);
  endtask

  task automatic t_chain();
    logic [15:0] pat = 16'b1011_0010_0111_0100;
    for (int i = 0; i < 16; i++) run_bit(pat[i], 0, 0);
  endtask

  task automatic t_busy_start();
    run_bit(1'b1, 3, T);
    run_bit(1'b0, P + 1, P + X + L + 2);
  endtask

  task automatic t_idle_noise();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      latch_dec = ~latch_dec;
      chk_idle("R9 idle");
      chk("R7 dec_out idle", dec_out, exp_dec);
    end
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_chain();
        t_busy_start();
        t_idle_noise();
        run_bit(1'b1, 0, 0);
        t_reset();
        exp_set = 1'b0;
        exp_dec = 1'b0;
        run_bit(1'b0, 0, 0);
        run_bit(1'b1, 0, 0);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule